// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

This block sits behind a six-stage pipelined analog-to-digital converter in which every stage resolves one and a half bits and hands over a 2-bit raw code. A stage produces its code for a given sample one clock after the stage in front of it. So on any one clock edge the six codes on the input bus belong to six different samples. The block delays each stage's code by the right number of clocks so that the six codes of one sample meet. It then adds them with a one-bit overlap through a chain of ripple-carry adders built from full-adder cells. The result is one corrected 6-bit word per clock, qualified by a valid flag.

A valid bit enters together with the first stage's code and travels down its own delay chain. A result is therefore announced only after every stage has delivered its part of the sample. Raw codes of 11 are out of range. They are folded to 10, and if they arrive on a stage whose sample is valid they set a sticky error flag that only reset clears. A sum that does not fit in six bits is clipped to the largest 6-bit value.

Top module: `adc_corr_top`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_code` and `code_err` are all 0.
- R2: Stage k's code sits on `stage_codes[2k+1:2k]` (stage 0 is the first stage). A code seen on stage k at clock edge t belongs to the sample whose stage-0 code was seen at edge t−k.
- R3: For each valid sample, `out_code` equals the sum over k = 0..5 of code_k × 2^(5−k), so stage 0 carries the most weight.
- R4: When that sum is above 63, `out_code` is 63. A sum of exactly 63 passes unchanged.
- R5: A sample whose stage-0 code is sampled at edge t, with `in_valid` high, appears with `out_valid` high for exactly one cycle after edge t+5 (six clocks of latency). A new sample is accepted on every clock.
- R6: A raw stage code of 11 contributes to the sum as if it were 10.
- R7: `code_err` rises after the first edge at which any stage presents 11 for a valid sample. Once set, it stays high until reset.
- R8: Codes that belong to samples entered with `in_valid` low produce no output and never set `code_err`.
- R9: While `out_valid` is low (reset excluded), `out_code` keeps the last value it presented.
- R10: Asserting reset mid-stream discards every sample in flight. None of them appears after reset is released, and `code_err` is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Marks the stage-0 code on this clock as the start of a real sample |
| stage_codes | input | 12 | Raw 2-bit codes of all six stages, stage k at bits [2k+1:2k] |
| out_valid | output | 1 | Corrected word on `out_code` is new this cycle |
| out_code | output | 6 | Corrected, saturated 6-bit output word |
| code_err | output | 1 | Sticky flag: an out-of-range code was seen on a valid sample |

## Verification
Single stages are driven alone, first with 01 and then with 10, while every other stage holds 00. Each result then shows one stage's weight, which tells a correct skew and shift from a swapped stage, a wrong delay depth or a wrong shift amount. Several sums sit right at the clip point: all-01 gives 63, and one more 10 on the last stage gives 64, which together with the all-10 case separates the clipping from the plain sum. Long runs of random legal codes, both back to back and interleaved with invalid samples carrying 11, check throughput, latency and that the error flag depends on validity. A valid 11 followed by a reset in the middle of a stream checks the folding, the stickiness and the flush.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  localparam int CODE_W = 2;

  typedef logic [CODE_W-1:0] stage_code_t;

  localparam stage_code_t CODE_BAD = 2'b11;
  localparam stage_code_t CODE_TOP = 2'b10;

  // Fold the out-of-range raw code onto the largest legal one.
  function automatic stage_code_t fold_code(input stage_code_t c);
    return (c == CODE_BAD) ? CODE_TOP : c;
  endfunction

endpackage

// File: rtl/adc_corr_fa.sv
module adc_corr_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);

  logic p;

  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (ci & p);

endmodule

// File: rtl/adc_corr_align.sv
module adc_corr_align
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [NUM_STAGES*CODE_W-1:0] codes_in,
  output logic [NUM_STAGES*CODE_W-1:0] codes_out,
  output logic [NUM_STAGES-1:0]        vld_tap
);

  // Valid chain: tap k is in_valid delayed by k clocks, i.e. the validity
  // of the sample that stage k is presenting right now.
  logic [NUM_STAGES-1:1] vld_q;
  logic [NUM_STAGES-1:1] vld_d;

  always_comb begin
    vld_d[1] = in_valid;
    for (int i = 2; i < NUM_STAGES; i++) begin
      vld_d[i] = vld_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign vld_tap = {vld_q, in_valid};

  // Per-stage skew compensation: stage k waits NUM_STAGES-1-k clocks.
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam int DEPTH = NUM_STAGES - 1 - k;
    if (DEPTH == 0) begin : g_thru
      assign codes_out[k*CODE_W +: CODE_W] = codes_in[k*CODE_W +: CODE_W];
    end else begin : g_dly
      stage_code_t sr_q [DEPTH];
      stage_code_t sr_d [DEPTH];

      always_comb begin
        sr_d[0] = codes_in[k*CODE_W +: CODE_W];
        for (int i = 1; i < DEPTH; i++) begin
          sr_d[i] = sr_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            sr_q[i] <= '0;
          end
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            sr_q[i] <= sr_d[i];
          end
        end
      end

      assign codes_out[k*CODE_W +: CODE_W] = sr_q[DEPTH-1];
    end
  end

endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 6,
  parameter int SUM_W      = NUM_STAGES + 1
) (
  input  logic [NUM_STAGES*CODE_W-1:0] codes,
  output logic [SUM_W-1:0]             sum,
  output logic                         ovf
);

  logic [NUM_STAGES:0][SUM_W-1:0] acc;
  logic [NUM_STAGES-1:0]          cout;

  assign acc[0] = '0;

  // One ripple-carry adder per stage; each adds the stage code shifted
  // one place less than the stage before, giving the one-bit overlap.
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_term
    localparam int SH = NUM_STAGES - 1 - k;
    logic [SUM_W-1:0] addend;
    logic [SUM_W:0]   cy;

    assign addend = SUM_W'(codes[k*CODE_W +: CODE_W]) << SH;
    assign cy[0]  = 1'b0;

    for (genvar b = 0; b < SUM_W; b++) begin : g_bit
      adc_corr_fa u_fa (
        .a  (acc[k][b]),
        .b  (addend[b]),
        .ci (cy[b]),
        .s  (acc[k+1][b]),
        .co (cy[b+1])
      );
    end

    assign cout[k] = cy[SUM_W];
  end

  assign sum = acc[NUM_STAGES];
  assign ovf = |cout;

endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
  output logic                         out_valid,
  output logic [NUM_STAGES-1:0]        out_code,
  output logic                         code_err
);

  localparam int OUT_W = NUM_STAGES;
  localparam int SUM_W = OUT_W + 1;
  localparam logic [OUT_W-1:0] OUT_MAX = '1;

  logic [NUM_STAGES*CODE_W-1:0] folded;
  logic [NUM_STAGES*CODE_W-1:0] aligned;
  logic [NUM_STAGES-1:0]        vld_tap;
  logic [NUM_STAGES-1:0]        bad_vec;
  logic                         bad_hit;
  logic                         vld_aligned;
  logic [SUM_W-1:0]             sum_raw;
  logic                         sum_ovf;
  logic [OUT_W-1:0]             sat_code;

  logic             out_valid_q, out_valid_d;
  logic [OUT_W-1:0] out_code_q,  out_code_d;
  logic             err_q,       err_d;

  // Fold and range-check each incoming code against its own sample's valid.
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_chk
    assign folded[k*CODE_W +: CODE_W] = fold_code(stage_codes[k*CODE_W +: CODE_W]);
    assign bad_vec[k] = (stage_codes[k*CODE_W +: CODE_W] == CODE_BAD) & vld_tap[k];
  end

  assign bad_hit = |bad_vec;

  adc_corr_align #(
    .NUM_STAGES (NUM_STAGES)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .codes_in  (folded),
    .codes_out (aligned),
    .vld_tap   (vld_tap)
  );

  assign vld_aligned = vld_tap[NUM_STAGES-1];

  adc_corr_sum #(
    .NUM_STAGES (NUM_STAGES),
    .SUM_W      (SUM_W)
  ) u_sum (
    .codes (aligned),
    .sum   (sum_raw),
    .ovf   (sum_ovf)
  );

  // The top bit of the sum is set exactly when the value exceeds OUT_MAX.
  assign sat_code = sum_raw[OUT_W] ? OUT_MAX : sum_raw[OUT_W-1:0];

  always_comb begin
    out_valid_d = vld_aligned;
    out_code_d  = vld_aligned ? sat_code : out_code_q;
    err_d       = err_q | bad_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_code_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      out_code_q  <= out_code_d;
      err_q       <= err_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_code  = out_code_q;
  assign code_err  = err_q;

  // R3: legal and folded codes never carry out of the widened sum.
  a_r3_no_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_ovf);

  // R4: an aligned sample whose sum is beyond range is presented clipped.
  a_r4_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_aligned && (sum_raw > SUM_W'(OUT_MAX))) |=> (out_code == OUT_MAX));

  // R7: error flag rises after a bad code on a valid sample.
  a_r7_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hit |=> code_err);

  // R7: error flag never falls outside reset.
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  // R9: output word holds while no new sample lands.
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_aligned |=> $stable(out_code));

  // R5: every output pulse follows a sample taken at the head of the pipe.
  a_r5_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(vld_tap[NUM_STAGES-1]));

endmodule

// File: tb/adc_corr_top_test.sv
module adc_corr_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int MAXS = 2048;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [2*NS-1:0] stage_codes = '0;
  logic            out_valid;
  logic [NS-1:0]   out_code;
  logic            code_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_corr_top #(.NUM_STAGES(NS)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .stage_codes (stage_codes),
    .out_valid   (out_valid),
    .out_code    (out_code),
    .code_err    (code_err)
  );

  typedef struct {
    int    val;
    int    stamp;
    string req;
  } exp_t;

  exp_t        exq[$];
  logic [1:0]  sc [MAXS][NS];
  bit          sv [MAXS];
  int          n_drv = 0;
  int          base = 0;
  int          edge_n = 0;
  int          checks = 0;
  int          fails = 0;
  int          out_seen = 0;
  bit          bad_now = 0;
  bit          exp_err = 0;
  bit          done = 0;
  logic [NS-1:0] last_out = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp_v, edge_n);
    end
  endtask

  function automatic int model(input int idx);
    int s;
    int c;
    s = 0;
    for (int k = 0; k < NS; k++) begin
      c = int'(sc[idx][k]);
      if (c == 3) c = 2;          // R6 folding
      s += c << (NS - 1 - k);     // R3 weighting
    end
    if (s > 63) s = 63;           // R4 clipping
    return s;
  endfunction

  // Driver: stores the new sample, then rebuilds the staggered bus (R2).
  task automatic drive(input bit v, input logic [2*NS-1:0] cv, input string tag);
    logic [2*NS-1:0] bus;
    bit bad;
    int idx;
    exp_t e;
    @(negedge clk);
    sv[n_drv] = v;
    for (int k = 0; k < NS; k++) sc[n_drv][k] = cv[2*k +: 2];
    bus = '0;
    bad = 1'b0;
    for (int k = 0; k < NS; k++) begin
      idx = n_drv - k;
      if (idx >= base) begin
        bus[2*k +: 2] = sc[idx][k];
        if (sv[idx] && sc[idx][k] == 2'b11) bad = 1'b1;
      end
    end
    in_valid    = v;
    stage_codes = bus;
    bad_now     = bad;
    if (v) begin
      e.val   = model(n_drv);
      e.stamp = edge_n + 1;
      e.req   = tag;
      exq.push_back(e);
    end
    n_drv++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, "R5");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    stage_codes = '0;
    bad_now     = 1'b0;
    exq.delete();
    repeat (2) @(negedge clk);
    base  = n_drv;
    rst_n = 1'b1;
  endtask

  function automatic logic [2*NS-1:0] rand_legal();
    logic [2*NS-1:0] v;
    for (int k = 0; k < NS; k++) v[2*k +: 2] = 2'($urandom_range(0, 2));
    return v;
  endfunction

  function automatic logic [2*NS-1:0] fill(input logic [1:0] c);
    logic [2*NS-1:0] v;
    for (int k = 0; k < NS; k++) v[2*k +: 2] = c;
    return v;
  endfunction

  // Monitor / scoreboard, sampling a quarter period after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      edge_n++;
      #(CLK_PERIOD/4);
      if (!rst_n) begin
        check(out_valid == 1'b0 && out_code == '0 && code_err == 1'b0, "R1",
              {out_valid, out_code, code_err}, 0);
        last_out = '0;
        exp_err  = 1'b0;
      end else begin
        exp_err = exp_err | bad_now;
        check(code_err == exp_err, "R7", code_err, exp_err);
        if (out_valid) begin
          out_seen++;
          if (exq.size() == 0) begin
            check(1'b0, "R5", 1, 0);
          end else begin
            e = exq.pop_front();
            check(int'(out_code) == e.val, e.req, out_code, e.val);
            check(edge_n == e.stamp + 5, "R5", edge_n, e.stamp + 5);
          end
          last_out = out_code;
        end else begin
          check(out_code == last_out, "R9", out_code, last_out);
          if (exq.size() > 0 && exq[0].stamp + 5 <= edge_n) begin
            e = exq.pop_front();
            check(1'b0, "R5", 0, 1);
          end
        end
      end
    end
  end

  initial begin
    int seen0;
    do_reset();

    // R3: all-zero sample.
    drive(1'b1, fill(2'b00), "R3");

    // R2: one stage at a time, shows each stage's weight and skew.
    for (int k = 0; k < NS; k++) begin
      drive(1'b1, 12'(2'b01) << (2*k), "R2");
      drive(1'b1, 12'(2'b10) << (2*k), "R2");
    end

    // R4: clip boundary.
    drive(1'b1, fill(2'b01), "R4");                         // 63 exact
    drive(1'b1, {2'b10, {(NS-1){2'b01}}}, "R4");            // 64 -> 63
    drive(1'b1, fill(2'b10), "R4");                         // 126 -> 63
    drive(1'b1, {{(NS-1){2'b00}}, 2'b10}, "R4");            // 64 -> 63

    // R5: back-to-back random legal samples.
    for (int i = 0; i < 150; i++) drive(1'b1, rand_legal(), "R5");
    idle(8);
    check(code_err == 1'b0, "R7", code_err, 0);

    // R8: invalid samples carrying out-of-range codes.
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 1) == 1) drive(1'b1, rand_legal(), "R8");
      else drive(1'b0, 12'($urandom()), "R8");
    end
    idle(8);
    check(code_err == 1'b0, "R8", code_err, 0);

    // R6 / R7: a valid 11 is folded and sets the sticky flag.
    drive(1'b1, {2'b01, 2'b01, 2'b01, 2'b11, 2'b01, 2'b01}, "R6");
    drive(1'b1, {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11}, "R6");
    idle(8);
    check(code_err == 1'b1, "R7", code_err, 1);
    for (int i = 0; i < 20; i++) drive(1'b1, rand_legal(), "R3");
    idle(8);
    check(code_err == 1'b1, "R7", code_err, 1);

    // R10: reset while samples are in flight.
    for (int i = 0; i < 3; i++) drive(1'b1, rand_legal(), "R10");
    do_reset();
    seen0 = out_seen;
    idle(10);
    check(out_seen == seen0, "R10", out_seen - seen0, 0);
    check(code_err == 1'b0, "R10", code_err, 0);

    // Pipeline usable again after the flush.
    for (int i = 0; i < 30; i++) drive(1'b1, rand_legal(), "R3");
    idle(8);
    check(exq.size() == 0, "R5", exq.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule